// File: doc/BRIEF.md
# Phase-Detector Lock Supervisor

This block watches the UP and DOWN pulse outputs of a phase-frequency detector and reports whether the loop is locked. Both pulse lines are first brought into the reference-clock domain by a short flip-flop synchroniser. On every reference clock in which both synchronised lines are high together, an expiry counter is refilled from a programmable window value. On every clock in which they are not, the counter steps down by one. When the counter reaches its end, a one-cycle unlock pulse is produced.

A second counter measures how long the pulses have been coincident without a break. Once that run reaches the window length, the lock flag rises. A mode input picks one of two behaviours. In latched mode the flag stays high until active mode ends. In tracking mode the flag falls on every expiry and can be set again later.

The window value is taken in only while the block is held in reset or is outside active mode. A window of zero acts as a window of one.

Top module: `pfd_lock_monitor`

## Requirements
- R1: UP and DOWN pass through a two-stage synchroniser. With window 1 and coincident pulses first applied before clock edge 1, `lock_o` is still low after edge 3 and is high after edge 4.
- R2: In any active cycle where the synchronised UP and DOWN are both high, the expiry counter is reloaded with the window value. No unlock pulse follows that cycle.
- R3: While the synchronised pulses are not coincident, the expiry counter decreases by one per clock. An unlock event occurs on exactly the window-th consecutive non-coincident cycle after a reload. A shorter non-coincident run causes no event.
- R4: `unlock_pulse_o` is high for one cycle per expiry and only in active mode. After reset or mode entry the counter is empty, so there is no expiry before the first reload.
- R5: `lock_o` rises one cycle after the coincident run reaches the window length. A shorter coincident run does not set it.
- R6: With `hold_mode` = 0 (latched), once `lock_o` is high it stays high for as long as `act_en` stays high, through any expiry.
- R7: With `hold_mode` = 1 (tracking), an expiry clears `lock_o` in the same cycle that `unlock_pulse_o` rises. Expiry takes priority over setting the flag.
- R8: Synchronous reset, or `act_en` low at a clock edge, clears `lock_o`, `unlock_pulse_o` and both counters.
- R9: `win_cfg` is captured only while `rst` is high or `act_en` is low. A change during active mode has no effect until the next mode entry.
- R10: A captured `win_cfg` of 0 behaves as a window of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| act_en | input | 1 | Active-mode enable; low clears and rearms the block |
| pfd_up | input | 1 | UP pulse from the phase detector (asynchronous) |
| pfd_dn | input | 1 | DOWN pulse from the phase detector (asynchronous) |
| win_cfg | input | WIN_W | Window length in reference clocks (0 treated as 1) |
| hold_mode | input | 1 | 0 = latched lock flag, 1 = tracking lock flag |
| lock_o | output | 1 | Lock flag |
| unlock_pulse_o | output | 1 | One-cycle expiry (unlock) pulse |

## Verification
The bench builds the block with a 4-bit window and the default two synchroniser stages. With that width it can reach the largest window (15) as well as the zero-to-one clamp in runs of only a few tens of cycles. A window of 3 drives the segment table. With that value, runs of exactly window-1 and window non-coincident cycles can be set against each other in both modes. The largest window is used to show that a mid-run edit of `win_cfg` is ignored, and that runs one cycle short of the window produce neither lock nor expiry.

// File: rtl/lockmon_pkg.sv
package lockmon_pkg;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_pair_t;

    typedef enum logic {
        LK_LATCHED  = 1'b0,
        LK_TRACKING = 1'b1
    } lk_mode_e;

    function automatic logic is_coincident(input pfd_pair_t p);
        return p.up & p.dn;
    endfunction

endpackage

// File: rtl/lockmon_sync.sv
module lockmon_sync
    import lockmon_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  pfd_pair_t d,
    output pfd_pair_t q
);
    localparam int NBITS = $bits(pfd_pair_t);

    logic [NBITS-1:0] d_vec;
    logic [NBITS-1:0] q_vec;

    assign d_vec = d;
    assign q     = q_vec;

    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d_vec[b]};
        end
        assign q_vec[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/lockmon_expiry.sv
module lockmon_expiry #(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_en,
    input  logic             coin,
    input  logic [WIN_W-1:0] reload,
    output logic             expire_now,
    output logic             unlock_pulse
);
    logic [WIN_W-1:0] cnt;

    // Counter is about to step from one to zero on a non-coincident cycle.
    assign expire_now = act_en && !coin && (cnt == WIN_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !act_en) begin
            cnt          <= '0;
            unlock_pulse <= 1'b0;
        end else begin
            unlock_pulse <= expire_now;
            if (coin)
                cnt <= reload;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/lockmon_lockflag.sv
module lockmon_lockflag
    import lockmon_pkg::*;
#(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_en,
    input  logic             coin,
    input  logic [WIN_W-1:0] window,
    input  logic             expire_now,
    input  lk_mode_e         mode,
    output logic             lock
);
    logic [WIN_W-1:0] run_len;
    logic             run_full;

    assign run_full = (run_len == window);

    always_ff @(posedge clk) begin
        if (rst || !act_en) begin
            run_len <= '0;
            lock    <= 1'b0;
        end else begin
            if (!coin)
                run_len <= '0;
            else if (!run_full)
                run_len <= run_len + 1'b1;

            if (mode == LK_TRACKING) begin
                if (expire_now)    lock <= 1'b0;
                else if (run_full) lock <= 1'b1;
            end else begin
                lock <= lock | run_full;
            end
        end
    end
endmodule

// File: rtl/pfd_lock_monitor.sv
module pfd_lock_monitor
    import lockmon_pkg::*;
#(
    parameter int WIN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_en,
    input  logic             pfd_up,
    input  logic             pfd_dn,
    input  logic [WIN_W-1:0] win_cfg,
    input  logic             hold_mode,
    output logic             lock_o,
    output logic             unlock_pulse_o
);
    pfd_pair_t        pfd_raw;
    pfd_pair_t        pfd_s;
    logic             coin;
    logic             expire_now;
    logic [WIN_W-1:0] win_eff;
    logic [WIN_W-1:0] win_q;

    assign pfd_raw = '{up: pfd_up, dn: pfd_dn};

    lockmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pfd_raw),
        .q   (pfd_s)
    );

    assign coin    = is_coincident(pfd_s);
    assign win_eff = (win_cfg == '0) ? WIN_W'(1) : win_cfg;

    // Window is only taken while idle, so edits during a run cannot bite.
    always_ff @(posedge clk) begin
        if (rst || !act_en) win_q <= win_eff;
    end

    lockmon_expiry #(.WIN_W(WIN_W)) u_expiry (
        .clk          (clk),
        .rst          (rst),
        .act_en       (act_en),
        .coin         (coin),
        .reload       (win_q),
        .expire_now   (expire_now),
        .unlock_pulse (unlock_pulse_o)
    );

    lockmon_lockflag #(.WIN_W(WIN_W)) u_flag (
        .clk        (clk),
        .rst        (rst),
        .act_en     (act_en),
        .coin       (coin),
        .window     (win_q),
        .expire_now (expire_now),
        .mode       (lk_mode_e'(hold_mode)),
        .lock       (lock_o)
    );
endmodule

// File: rtl/lockmon_checker.sv
module lockmon_checker (
    input logic clk,
    input logic rst,
    input logic act_en,
    input logic hold_mode,
    input logic coin,
    input logic lock_o,
    input logic unlock_pulse_o
);
    // R2: a coincident active cycle is never followed by an unlock pulse
    a_r2_coin_no_pulse: assert property (@(posedge clk) disable iff (rst)
        (coin && act_en) |=> !unlock_pulse_o);

    // R4: the pulse lasts one cycle
    a_r4_pulse_single: assert property (@(posedge clk) disable iff (rst)
        unlock_pulse_o |=> !unlock_pulse_o);

    // R4: the pulse only follows an active cycle
    a_r4_pulse_active: assert property (@(posedge clk) disable iff (rst)
        unlock_pulse_o |-> $past(act_en));

    // R6: latched flag holds while active
    a_r6_latched_hold: assert property (@(posedge clk) disable iff (rst)
        (act_en && !hold_mode && lock_o) |=> lock_o);

    // R7: in tracking mode an expiry clears the flag together with the pulse
    a_r7_track_drop: assert property (@(posedge clk) disable iff (rst)
        (unlock_pulse_o && $past(hold_mode)) |-> !lock_o);

    // R8: leaving active mode clears both outputs
    a_r8_idle_clear: assert property (@(posedge clk) disable iff (rst)
        !act_en |=> (!lock_o && !unlock_pulse_o));
endmodule

bind pfd_lock_monitor lockmon_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .act_en         (act_en),
    .hold_mode      (hold_mode),
    .coin           (coin),
    .lock_o         (lock_o),
    .unlock_pulse_o (unlock_pulse_o)
);

// File: tb/sim_pfd_lock_monitor.sv
module sim_pfd_lock_monitor;
    localparam int WIN_W = 4;

    typedef struct packed {
        logic       act;
        logic       mode;
        logic       up;
        logic       dn;
        logic [4:0] len;
        logic       chk_all;
        logic       exp_lock;
        logic [3:0] exp_pulses;
    } seg_t;

    localparam int NSEG = 11;
    // window 3 throughout the table
    localparam seg_t SEGS [NSEG] = '{
        '{1'b1, 1'b1, 1'b0, 1'b0, 5'd10, 1'b0, 1'b0, 4'd0}, // R4 no reload yet, no expiry
        '{1'b1, 1'b1, 1'b1, 1'b1, 5'd10, 1'b0, 1'b1, 4'd0}, // R5 lock gained
        '{1'b1, 1'b1, 1'b1, 1'b0, 5'd2,  1'b1, 1'b1, 4'd0}, // R3 short gap tolerated
        '{1'b1, 1'b1, 1'b1, 1'b1, 5'd10, 1'b1, 1'b1, 4'd0}, // R3 still locked
        '{1'b1, 1'b1, 1'b0, 1'b1, 5'd3,  1'b0, 1'b0, 4'd0}, // R3 gap of exactly window
        '{1'b1, 1'b1, 1'b1, 1'b1, 5'd10, 1'b0, 1'b1, 4'd1}, // R3 one expiry, relock
        '{1'b1, 1'b1, 1'b0, 1'b0, 5'd10, 1'b0, 1'b0, 4'd2}, // R7 tracking drop
        '{1'b1, 1'b0, 1'b1, 1'b1, 5'd10, 1'b0, 1'b1, 4'd2}, // R5 latched lock
        '{1'b1, 1'b0, 1'b1, 1'b0, 5'd10, 1'b0, 1'b1, 4'd3}, // R6 latched survives expiry
        '{1'b0, 1'b0, 1'b1, 1'b1, 5'd5,  1'b0, 1'b0, 4'd3}, // R8 idle clears
        '{1'b1, 1'b0, 1'b1, 1'b1, 5'd10, 1'b0, 1'b1, 4'd3}  // R5 relock on re-entry
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             act_en;
    logic             pfd_up;
    logic             pfd_dn;
    logic [WIN_W-1:0] win_cfg;
    logic             hold_mode;
    logic             lock_o;
    logic             unlock_pulse_o;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pfd_lock_monitor #(.WIN_W(WIN_W), .SYNC_STAGES(2)) u0 (
        .clk            (clk),
        .rst            (rst),
        .act_en         (act_en),
        .pfd_up         (pfd_up),
        .pfd_dn         (pfd_dn),
        .win_cfg        (win_cfg),
        .hold_mode      (hold_mode),
        .lock_o         (lock_o),
        .unlock_pulse_o (unlock_pulse_o)
    );

    task automatic tick();
        @(posedge clk);
        #2;
        if (unlock_pulse_o) pulses++;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input logic a, input logic m, input logic u, input logic d, input int n);
        act_en = a; hold_mode = m; pfd_up = u; pfd_dn = d;
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        rst = 1'b1; act_en = 1'b0; pfd_up = 1'b0; pfd_dn = 1'b0;
        win_cfg = 4'd3; hold_mode = 1'b1;
        tick(); tick(); tick();
        check("R8 reset lock", int'(lock_o), 0);
        check("R8 reset pulse", int'(unlock_pulse_o), 0);
        rst = 1'b0;
        tick();

        // segment table
        for (int s = 0; s < NSEG; s++) begin
            act_en = SEGS[s].act; hold_mode = SEGS[s].mode;
            pfd_up = SEGS[s].up;  pfd_dn = SEGS[s].dn;
            for (int i = 0; i < int'(SEGS[s].len); i++) begin
                tick();
                if (SEGS[s].chk_all)
                    check("R3 gap lock held", int'(lock_o), int'(SEGS[s].exp_lock));
            end
            if (!SEGS[s].chk_all && s != 4)
                check("R5/R6/R7/R8 lock", int'(lock_o), int'(SEGS[s].exp_lock));
            check("R3/R4 pulse count", pulses, int'(SEGS[s].exp_pulses));
        end

        // R9: mid-run window edit ignored (captured 3, edit to 15)
        base = pulses;
        win_cfg = 4'd15;
        run(1'b1, 1'b1, 1'b0, 1'b1, 4);
        run(1'b1, 1'b1, 1'b1, 1'b1, 10);
        check("R9 pulse with captured window", pulses, base + 1);
        check("R9 relock with captured window", int'(lock_o), 1);

        // window 15 captured on idle
        run(1'b0, 1'b1, 1'b0, 1'b0, 2);
        run(1'b1, 1'b1, 1'b1, 1'b1, 12);
        check("R5 short coincident run no lock", int'(lock_o), 0);
        run(1'b1, 1'b1, 1'b1, 1'b1, 8);
        check("R5 full window lock", int'(lock_o), 1);
        base = pulses;
        run(1'b1, 1'b1, 1'b1, 1'b0, 14);
        run(1'b1, 1'b1, 1'b1, 1'b1, 5);
        check("R3 window-1 gap no expiry", pulses, base);
        run(1'b1, 1'b1, 1'b0, 1'b0, 15);
        run(1'b1, 1'b1, 1'b1, 1'b1, 5);
        check("R3 window gap expiry", pulses, base + 1);

        // R10 and R1: window 0 acts as 1, exact latency
        win_cfg = 4'd0;
        run(1'b0, 1'b1, 1'b0, 1'b0, 2);
        run(1'b1, 1'b1, 1'b1, 1'b1, 3);
        check("R1 latency lock still low", int'(lock_o), 0);
        tick();
        check("R1 lock after edge 4", int'(lock_o), 1);
        base = pulses;
        run(1'b1, 1'b1, 1'b0, 1'b1, 1);
        run(1'b1, 1'b1, 1'b1, 1'b1, 6);
        check("R10 single-cycle gap expires", pulses, base + 1);

        // R8: reset while locked
        rst = 1'b1;
        tick();
        check("R8 reset clears lock", int'(lock_o), 0);
        check("R8 reset clears pulse", int'(unlock_pulse_o), 0);
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule